// File: doc/BRIEF.md
# Four-Channel GPIO Edge Capture Unit

This block timestamps edges on general-purpose I/O lines. Each of its four channels picks one line from a 32-bit GPIO bus, or none. It brings the chosen line into the local clock domain and watches it for a rising or falling edge. On a detected edge the channel copies the free-running 24-bit timer value into its own capture register and sets a sticky pending flag.

Software clears a pending flag with a one-cycle clear pulse. A per-channel interrupt enable decides whether a pending channel drives the shared capture interrupt. The timer itself lives outside this block and arrives as an input. The synchronised level of every channel is also brought out, so a status register can show it.

Top module: `evcap_unit`

## Requirements
- R1: A channel whose 6-bit select code (channel c uses bits [6c+5:6c] of `sel_i`) is 0, or any value above 32, is disabled. Its synchronised level is held at 0 and it makes no new events once its pipeline has drained.
- R2: Select code k, for k from 1 to 32, connects GPIO bit k-1 to the channel.
- R3: `level_o[c]` shows the selected GPIO value sampled on the second clock edge after it is applied, through a two-flop synchroniser.
- R4: `fall_i[c]` = 0 detects rising edges of the synchronised level, and 1 detects falling edges.
- R5: An event is recognised one cycle after the synchronised level changes in the chosen direction. On the clock edge that ends that cycle, the capture register stores the `timer_i` value present at that edge.
- R6: A new event overwrites the capture register even when the channel's pending flag is already set.
- R7: An event sets the channel's pending flag, and the flag stays set until it is cleared.
- R8: `clr_i[c]` high at a clock edge clears the pending flag. If an event and a clear arrive at the same edge, the flag ends set.
- R9: `irq_o` is the OR over channels of (pending AND `irq_en_i`). The enable has no effect on pending flags or captures.
- R10: While `rst_n` is low at a clock edge, all capture registers, pending flags and levels go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gpio_i | input | 32 | Asynchronous GPIO lines |
| timer_i | input | 24 | Current timer value |
| sel_i | input | 24 | Four 6-bit line-select codes, channel 0 in the low bits |
| fall_i | input | 4 | Edge polarity per channel, 1 = falling |
| irq_en_i | input | 4 | Interrupt enable per channel |
| clr_i | input | 4 | Pending-clear pulses per channel |
| cap_o | output | 96 | Four 24-bit capture registers, channel 0 in the low bits |
| pend_o | output | 4 | Pending flags |
| level_o | output | 4 | Synchronised channel input levels |
| irq_o | output | 1 | Shared capture interrupt |

## Verification
The random phase toggles sparse GPIO bits and draws select codes from 0 to 40. Out-of-range and disabled codes therefore mix with valid ones, and a mis-decoded mux or an off-by-one line index shows up as wrong levels or wrong captures. A random timer value on every cycle shows whether a capture took the timer from the correct cycle rather than a neighbouring one. Randomly timed clear pulses and enables exercise the sticky flag, the collision of clear and event, and the interrupt masking. Directed phases then single out falling-edge polarity, overwrite while pending, a forced clear-and-event collision, and a disabled channel under heavy toggling.

// File: rtl/evcap_pkg.sv
// Shared constants and helpers for the GPIO edge capture unit.
// Assumes select codes are unsigned and that code 0 means "no line".
package evcap_pkg;
    localparam int unsigned DEF_CHANNELS = 4;
    localparam int unsigned DEF_GPIO_W   = 32;
    localparam int unsigned DEF_TS_W     = 24;
    localparam int unsigned DEF_SEL_W    = 6;
    localparam int unsigned DEF_SYNC     = 2;

    // Edge polarity encoding carried on the fall inputs.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;
endpackage

// File: rtl/evcap_insel.sv
// Input selector: routes one GPIO line to a channel.
// Code k (1..GPIO_W) selects gpio[k-1]; 0 or any larger code gives constant 0.
// Purely combinational; the caller synchronises the result.
module evcap_insel #(
    parameter int unsigned GPIO_W = 32,
    parameter int unsigned SEL_W  = 6
) (
    input  logic [GPIO_W-1:0] gpio,
    input  logic [SEL_W-1:0]  sel,
    output logic              picked
);
    // Decode the select code against every line position.
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < GPIO_W; i++) begin
            if (sel == SEL_W'(i + 1)) picked = gpio[i];
        end
    end
endmodule

// File: rtl/evcap_sync.sv
// Multi-flop synchroniser for one asynchronous bit.
// Assumes STAGES >= 2; output lags input by STAGES clock edges.
module evcap_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the sampled bit through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/evcap_chan.sv
// One capture channel: line select, synchroniser, edge detect,
// timestamp register and sticky pending flag.
// Assumes timer is synchronous to clk. Event beats clear in the same cycle.
module evcap_chan
    import evcap_pkg::*;
#(
    parameter int unsigned GPIO_W = DEF_GPIO_W,
    parameter int unsigned SEL_W  = DEF_SEL_W,
    parameter int unsigned TS_W   = DEF_TS_W,
    parameter int unsigned SYNC   = DEF_SYNC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GPIO_W-1:0] gpio,
    input  logic [SEL_W-1:0]  sel,
    input  logic              fall,
    input  logic              clr,
    input  logic [TS_W-1:0]   timer,
    output logic              level,
    output logic              pend,
    output logic [TS_W-1:0]   cap
);
    logic      raw;
    logic      prev;
    logic      evt;
    edge_pol_e pol;

    evcap_insel #(.GPIO_W(GPIO_W), .SEL_W(SEL_W)) u_sel (
        .gpio   (gpio),
        .sel    (sel),
        .picked (raw)
    );

    evcap_sync #(.STAGES(SYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw),
        .q     (level)
    );

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= level;
    end

    assign pol = edge_pol_e'(fall);

    // Flag a transition in the chosen direction.
    always_comb begin
        if (pol == EDGE_FALL) evt = prev & ~level;
        else                  evt = level & ~prev;
    end

    // Latch the timer value on every event, pending or not.
    always_ff @(posedge clk) begin
        if (!rst_n)   cap <= '0;
        else if (evt) cap <= timer;
    end

    // Sticky pending flag; set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend <= 1'b0;
        else if (evt) pend <= 1'b1;
        else if (clr) pend <= 1'b0;
    end

    // R7
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pend);

    // R5
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (cap == $past(timer)));

    // R6
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(cap));

    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !pend);

    // R1
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) ##1 (sel == '0) |=> (level == 1'b0));
endmodule

// File: rtl/evcap_unit.sv
// Top of the GPIO edge capture unit: replicated channels plus the
// shared interrupt combiner. Channel c occupies slice c of each packed bus.
module evcap_unit
    import evcap_pkg::*;
#(
    parameter int unsigned CHANNELS = DEF_CHANNELS,
    parameter int unsigned GPIO_W   = DEF_GPIO_W,
    parameter int unsigned TS_W     = DEF_TS_W,
    parameter int unsigned SEL_W    = DEF_SEL_W,
    parameter int unsigned SYNC     = DEF_SYNC
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [GPIO_W-1:0]        gpio_i,
    input  logic [TS_W-1:0]          timer_i,
    input  logic [CHANNELS*SEL_W-1:0] sel_i,
    input  logic [CHANNELS-1:0]      fall_i,
    input  logic [CHANNELS-1:0]      irq_en_i,
    input  logic [CHANNELS-1:0]      clr_i,
    output logic [CHANNELS*TS_W-1:0] cap_o,
    output logic [CHANNELS-1:0]      pend_o,
    output logic [CHANNELS-1:0]      level_o,
    output logic                     irq_o
);
    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        evcap_chan #(
            .GPIO_W (GPIO_W),
            .SEL_W  (SEL_W),
            .TS_W   (TS_W),
            .SYNC   (SYNC)
        ) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .gpio  (gpio_i),
            .sel   (sel_i[c*SEL_W +: SEL_W]),
            .fall  (fall_i[c]),
            .clr   (clr_i[c]),
            .timer (timer_i),
            .level (level_o[c]),
            .pend  (pend_o[c]),
            .cap   (cap_o[c*TS_W +: TS_W])
        );
    end

    // Combine enabled pending flags into the shared interrupt.
    always_comb irq_o = |(pend_o & irq_en_i);

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_i == '0) |-> !irq_o);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pend_o == '0 && level_o == '0));
endmodule

// File: tb/tb_evcap_unit.sv
module tb_evcap_unit;
    localparam int NCH = 4;
    localparam int GW  = 32;
    localparam int TW  = 24;
    localparam int SW  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [GW-1:0]     gpio_i = '0;
    logic [TW-1:0]     timer_i = '0;
    logic [NCH*SW-1:0] sel_i = '0;
    logic [NCH-1:0]    fall_i = '0;
    logic [NCH-1:0]    irq_en_i = '0;
    logic [NCH-1:0]    clr_i = '0;
    logic [NCH*TW-1:0] cap_o;
    logic [NCH-1:0]    pend_o;
    logic [NCH-1:0]    level_o;
    logic              irq_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    evcap_unit dut (.*);

    always #5 clk = ~clk;

    // Reference state built from the requirements.
    logic [NCH-1:0] m_s1 = '0, m_lvl = '0, m_prv = '0, m_pend = '0;
    logic [TW-1:0]  m_cap [NCH];
    initial for (int c = 0; c < NCH; c++) m_cap[c] = '0;

    function automatic logic pick_line(logic [GW-1:0] g, logic [SW-1:0] s);
        if (s >= 1 && s <= GW) return g[s-1];   // R2, R1
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            logic ev;
            if (!rst_n) begin
                m_s1[c] = 0; m_lvl[c] = 0; m_prv[c] = 0; m_pend[c] = 0; m_cap[c] = '0;
            end else begin
                ev = fall_i[c] ? (m_prv[c] & ~m_lvl[c]) : (m_lvl[c] & ~m_prv[c]);
                if (ev) begin m_pend[c] = 1; m_cap[c] = timer_i; end
                else if (clr_i[c]) m_pend[c] = 0;
                m_prv[c] = m_lvl[c];
                m_lvl[c] = m_s1[c];
                m_s1[c]  = pick_line(gpio_i, sel_i[c*SW +: SW]);
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int c = 0; c < NCH; c++) begin
            chk({tag, " R3 level"}, 32'(level_o[c]), 32'(m_lvl[c]));
            chk({tag, " R7 pending"}, 32'(pend_o[c]), 32'(m_pend[c]));
            chk({tag, " R5 capture"}, 32'(cap_o[c*TW +: TW]), 32'(m_cap[c]));
        end
        chk({tag, " R9 irq"}, 32'(irq_o), 32'(|(m_pend & irq_en_i)));
    endtask

    task automatic step(string tag);
        @(negedge clk);
        check_all(tag);
        timer_i = TW'($urandom);
    endtask

    task automatic set_sel(int c, int v);
        sel_i[c*SW +: SW] = SW'(v);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: everything zero out of reset
        chk("R10 reset pend", 32'(pend_o), 0);
        chk("R10 reset level", 32'(level_o), 0);
        chk("R10 reset cap", 32'(cap_o[31:0]), 0);

        // R2/R4: ch0 on line 5 rising, ch1 on line 32 falling
        set_sel(0, 5); set_sel(1, 32); fall_i = 4'b0010;
        gpio_i[31] = 1'b1;
        repeat (4) step("R2 mux");
        gpio_i[4] = 1'b1; gpio_i[31] = 1'b0;
        repeat (5) step("R4 falling");
        chk("R4 falling pend ch1", 32'(pend_o[1]), 1);
        chk("R2 rising pend ch0", 32'(pend_o[0]), 1);

        // R6: second event overwrites while pending
        gpio_i[4] = 1'b0; repeat (3) step("R6 overwrite");
        gpio_i[4] = 1'b1; repeat (5) step("R6 overwrite");

        // R8: hold clear while an event arrives
        clr_i = 4'b0001;
        gpio_i[4] = 1'b0; repeat (3) step("R8 collision");
        gpio_i[4] = 1'b1; repeat (5) step("R8 collision");
        clr_i = '0;

        // R1: code 33 and code 0 under heavy toggling
        set_sel(2, 33); set_sel(3, 0); clr_i = 4'b1100;
        step("R1 disabled"); clr_i = '0;
        for (int i = 0; i < 20; i++) begin
            gpio_i = ~gpio_i;
            step("R1 disabled");
        end
        chk("R1 disabled pend", 32'(pend_o[3:2]), 0);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            if (i % 64 == 0) begin
                for (int c = 0; c < NCH; c++) set_sel(c, $urandom_range(0, 40));
                fall_i = NCH'($urandom);
                irq_en_i = NCH'($urandom);
            end
            gpio_i = gpio_i ^ ($urandom & $urandom & $urandom);
            clr_i = NCH'($urandom & $urandom & $urandom);
            step("random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule